// File: doc/BRIEF.md
# Successive approximation conversion sequencer

This block is the digital half of a charge-redistribution successive approximation converter. A start request launches a conversion. For one clock the block asserts a sample control, during which the capacitor array tracks the analog input. Then it runs a binary search over the array's digital word, one bit per clock, from the most significant bit down to the least.

In each trial the trial bit is raised in the switch word. Bits that are set steer their capacitor bottom plates to the reference, and cleared bits steer them to ground. The comparator reports the sign of the summing node. A negative node means the trial weight does not exceed the input, and the bit is kept. Otherwise the bit is dropped.

After the last decision the block raises a one-cycle done strobe and registers the code. The switch word is left equal to that code until the next conversion begins.

Top module: `sar_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, sample, busy and done are 0, and the switch word and code are all zeros.
- R2: A start seen at a clock edge while idle gives exactly one cycle with sample=1, busy=1 and an all-zero switch word.
- R3: In the cycle after the sample cycle, the switch word holds only the most significant bit (bit WIDTH-1) set.
- R4: At each trial edge, the current trial bit is kept when cmp_neg=1 and cleared when cmp_neg=0. Higher bits are unchanged, and the next lower bit is raised. Exactly one trial bit is under test at a time, and all bits below it are 0.
- R5: Exactly WIDTH trial cycles follow the sample cycle. Done is 1 for exactly one cycle, the cycle after the LSB decision edge, and busy is 0 in that cycle.
- R6: The code changes only in the cycle in which done is 1. It then equals the switch word, and both hold their values until the next conversion.
- R7: A start asserted while busy is ignored: the ongoing sequence and its timing are unaffected.
- R8: With WIDTH=6 and an input of 5/8 of the reference, the trial words are 32, 48, 40, 44, 42, 41 and the final code is 6'b101000.
- R9: When the comparator reports negative exactly when the trial word does not exceed the input, the final code is the largest word not exceeding the input, clamped to 2^WIDTH-1.
- R10: A start held high continuously launches a new conversion in the cycle right after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion request, sampled when idle |
| cmp_neg | input | 1 | Comparator: 1 when the summing node is negative (keep bit) |
| sample | output | 1 | Array tracks input (top plates grounded, bottom plates to input) |
| dac_word | output | WIDTH | Bottom-plate switch word: 1 = reference, 0 = ground |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle strobe, code valid |
| code | output | WIDTH | Converted code, held until the next done |

## Verification
The bench models the capacitor array as an ideal comparator against an input on a grid four times finer than one LSB, and a behavioural model predicts every output on every clock.

Each input pattern tells apart a different fault:
- Zero and full scale expose wrong keep/clear polarity, which would produce the opposite code.
- An input just below half scale separates a dropped MSB from the remaining all-ones search.
- An input exactly on a trial weight (5/8) shows the keep-on-equality rule together with the documented trial sequence.
- An alternating-bit input catches a trial pointer that skips or repeats a bit.
- Start pulses mid-conversion, a held start and a reset in mid-search probe the sequencing.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SAMPLE = 2'd1,
        PH_TRIAL  = 2'd2
    } sar_phase_e;

endpackage

// File: rtl/sar_seq.sv
module sar_seq
    import sar_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output sar_phase_e       phase,
    output logic [WIDTH-1:0] ptr,
    output logic             launch
);
    localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

    typedef struct packed {
        sar_phase_e       ph;
        logic [WIDTH-1:0] ptr;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        launch = 1'b0;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (start) begin
                    s_d.ph = PH_SAMPLE;
                    launch = 1'b1;
                end
            end
            PH_SAMPLE: begin
                s_d.ph  = PH_TRIAL;
                s_d.ptr = TOP_BIT;
            end
            PH_TRIAL: begin
                if (s_q.ptr[0]) begin
                    s_d.ph  = PH_IDLE;
                    s_d.ptr = '0;
                end else begin
                    s_d.ptr = s_q.ptr >> 1;
                end
            end
            default: s_d = '{ph: PH_IDLE, ptr: '0};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{ph: PH_IDLE, ptr: '0};
        else        s_q <= s_d;
    end

    assign phase = s_q.ph;
    assign ptr   = s_q.ptr;

    AST_SAMPLE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SAMPLE) |=> (phase == PH_TRIAL)) else $error("sample too long"); // R2
    AST_PTR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ptr)) else $error("pointer not onehot"); // R4
    AST_TRIAL_HAS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_TRIAL) |-> (ptr != '0)) else $error("trial without bit"); // R5

endmodule

// File: rtl/sar_trial.sv
module sar_trial
    import sar_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  sar_phase_e       phase,
    input  logic [WIDTH-1:0] ptr,
    input  logic             cmp_neg,
    output logic [WIDTH-1:0] word
);
    localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};
    localparam logic [WIDTH-1:0] ONE     = {{(WIDTH-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [WIDTH-1:0] word;
    } trial_t;

    trial_t t_d, t_q;
    logic [WIDTH-1:0] decided;

    always_comb begin
        decided = cmp_neg ? t_q.word : (t_q.word & ~ptr);
        t_d     = t_q;
        if (launch) begin
            t_d.word = '0;
        end else if (phase == PH_SAMPLE) begin
            t_d.word = TOP_BIT;
        end else if (phase == PH_TRIAL) begin
            t_d.word = decided | (ptr >> 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '{word: '0};
        else        t_q <= t_d;
    end

    assign word = t_q.word;

    AST_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SAMPLE) |=> (word == TOP_BIT)) else $error("msb trial wrong"); // R3
    AST_LOWER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_TRIAL) |-> ((word & (ptr - ONE)) == '0)) else $error("lower bits set"); // R4
    AST_TRIAL_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_TRIAL) |-> ((word & ptr) == ptr)) else $error("trial bit low"); // R4
    AST_SAMPLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SAMPLE) |-> (word == '0)) else $error("word not cleared"); // R2

endmodule

// File: rtl/sar_result.sv
module sar_result
    import sar_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  sar_phase_e       phase,
    input  logic [WIDTH-1:0] ptr,
    input  logic             cmp_neg,
    input  logic [WIDTH-1:0] word,
    output logic [WIDTH-1:0] code,
    output logic             done
);
    typedef struct packed {
        logic [WIDTH-1:0] code;
        logic             done;
    } res_t;

    res_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (phase == PH_TRIAL && ptr[0]) begin
            r_d.code = cmp_neg ? word : (word & ~ptr);
            r_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{code: '0, done: 1'b0};
        else        r_q <= r_d;
    end

    assign code = r_q.code;
    assign done = r_q.done;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done longer than one cycle"); // R5
    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(code)) else $error("code moved without done"); // R6
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (phase == PH_IDLE)) else $error("done while busy"); // R5

endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
    import sar_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cmp_neg,
    output logic             sample,
    output logic [WIDTH-1:0] dac_word,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] code
);
    sar_phase_e       phase;
    logic [WIDTH-1:0] ptr;
    logic             launch;

    sar_seq #(.WIDTH(WIDTH)) i_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .phase  (phase),
        .ptr    (ptr),
        .launch (launch)
    );

    sar_trial #(.WIDTH(WIDTH)) i_trial (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (launch),
        .phase   (phase),
        .ptr     (ptr),
        .cmp_neg (cmp_neg),
        .word    (dac_word)
    );

    sar_result #(.WIDTH(WIDTH)) i_result (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase   (phase),
        .ptr     (ptr),
        .cmp_neg (cmp_neg),
        .word    (dac_word),
        .code    (code),
        .done    (done)
    );

    assign sample = (phase == PH_SAMPLE);
    assign busy   = (phase != PH_IDLE);

    AST_DONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (dac_word == code)) else $error("word differs from code"); // R6
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !sample) |=> !sample) else $error("restart while busy"); // R7

endmodule

// File: tb/test_sar_ctrl.sv
module test_sar_ctrl;
    localparam int NB  = 6;
    localparam int MAX = (1 << NB) - 1;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n, start, cmp_neg;
    logic          sample, busy, done;
    logic [NB-1:0] dac_word, code;
    int            vin4;
    int            checks = 0, errors = 0, cyc = 0;

    // ideal array + comparator: node negative when trial weight <= input
    assign cmp_neg = (int'(dac_word) * 4 <= vin4);

    sar_ctrl #(.WIDTH(NB)) i_sar_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .cmp_neg(cmp_neg),
        .sample(sample), .dac_word(dac_word), .busy(busy), .done(done), .code(code)
    );

    // behavioural reference: phase 0 idle, 1 sample, 2 trial
    int m_ph, m_bit, m_dac, m_code, m_done;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph <= 0; m_bit <= 0; m_dac <= 0; m_code <= 0; m_done <= 0;
        end else begin
            m_done <= 0;
            if (m_ph == 0) begin
                if (start) begin m_ph <= 1; m_dac <= 0; end
            end else if (m_ph == 1) begin
                m_ph <= 2; m_bit <= NB - 1; m_dac <= 1 << (NB - 1);
            end else begin
                int w;
                w = (m_dac * 4 <= vin4) ? m_dac : m_dac - (1 << m_bit);
                if (m_bit == 0) begin
                    m_ph <= 0; m_dac <= w; m_code <= w; m_done <= 1;
                end else begin
                    m_bit <= m_bit - 1; m_dac <= w + (1 << (m_bit - 1));
                end
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n === 1'b1) begin
            chk("R2 sample", int'(sample), int'(m_ph == 1));
            chk("R5 busy", int'(busy), int'(m_ph != 0));
            chk("R5 done", int'(done), m_done);
            chk("R4 dac_word", int'(dac_word), m_dac);
            chk("R6 code", int'(code), m_code);
        end
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected <100000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic wait_done(output int lat);
        lat = 0;
        while (done !== 1'b1 && lat < 40) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic convert(input int v);
        int lat;
        vin4 = v;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        wait_done(lat);
        // sample cycle + NB trials; done seen NB+1 negedges after start released
        chk("R5 latency", lat, NB + 1);
        chk("R9 code", int'(code), (v / 4 > MAX) ? MAX : v / 4);
        chk("R6 word=code", int'(dac_word), int'(code));
    endtask

    initial begin
        int seq [NB];
        int exp_seq [NB] = '{32, 48, 40, 44, 42, 41};
        int lat;
        rst_n = 1'b0; start = 1'b0; vin4 = 0;
        repeat (3) @(negedge clk);
        chk("R1 sample", int'(sample), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 dac", int'(dac_word), 0);
        chk("R1 code", int'(code), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: 5/8 of reference, trial sequence recorded
        vin4 = 40 * 4;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk("R2 sample high", int'(sample), 1);
        chk("R2 word zero", int'(dac_word), 0);
        for (int i = 0; i < NB; i++) begin
            @(negedge clk);
            seq[i] = int'(dac_word);
        end
        chk("R3 msb first", seq[0], 32);
        for (int i = 0; i < NB; i++) chk("R8 trial word", seq[i], exp_seq[i]);
        @(negedge clk);
        chk("R8 final code", int'(code), 6'b101000);
        chk("R5 done strobe", int'(done), 1);

        convert(0);            // all bits cleared
        convert(MAX * 4 + 3);  // full scale
        convert(32 * 4 - 1);   // just below half: 011111
        convert(42 * 4 + 2);   // alternating bits
        convert(17 * 4 + 1);

        // R7: start pulses mid-conversion are ignored
        vin4 = 21 * 4;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (2) @(negedge clk);
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        wait_done(lat);
        chk("R7 latency unaffected", lat, NB - 2);
        chk("R7 code", int'(code), 21);
        repeat (2) @(negedge clk);
        chk("R7 stays idle", int'(busy), 0);

        // R10: start held high gives back-to-back conversions
        vin4 = 9 * 4;
        @(negedge clk) start = 1'b1;
        wait_done(lat);
        chk("R10 first code", int'(code), 9);
        @(negedge clk);
        chk("R10 restart sample", int'(sample), 1);
        start = 1'b0;
        wait_done(lat);
        chk("R10 second code", int'(code), 9);

        // R1: reset in the middle of a search
        vin4 = 50 * 4;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid reset busy", int'(busy), 0);
        chk("R1 mid reset code", int'(code), 0);
        chk("R1 mid reset dac", int'(dac_word), 0);
        rst_n = 1'b1;
        convert(50 * 4);

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule